// File: doc/BRIEF.md
# Dual-Digit Multiplexed Hex Display Driver

This block shows two 4-bit hex values on a pair of common-anode seven-segment digits. The two digits share one hex-to-segment decoder. A phase accumulator on the system clock makes a slow refresh tick. Each tick flips a one-bit digit selector. The selector picks which nibble is decoded and which digit is powered. The segment lines and the digit enables are both registered on the tick, so a lit digit never shows the other digit's pattern.

With the default settings the system clock is 48 MHz, the accumulator is 24 bits wide and the increment is 42. This gives about 120 ticks per second, so each digit is refreshed at about 60 Hz. The tick is a one-cycle enable inside the system clock domain. The whole block runs on a single clock with a synchronous active-high reset. Segment and enable outputs are active low. A low segment line lights that segment, and a low enable turns on the high-side switch of that digit.

Top module: `dual_seg7_mux`

## Requirements
- R1: Synchronous reset. While `rst_i` is high, every bit of `seg_n_o` and `dig_en_n_o` is 1 one clock later. Both outputs stay at all ones until the first tick after reset.
- R2: Tick rate. An accumulator of ACC_W bits starts at 0 at reset and adds INC on every clock. A tick happens on each clock where the add wraps past 2^ACC_W. Over N clocks after reset, exactly floor(N*INC/2^ACC_W) ticks occur. Each tick changes `dig_en_n_o`.
- R3: The digit select flips on every tick. The first tick after reset lights digit 1 (`dig_en_n_o` = 2'b01). After that the lit digit alternates between digit 0 (2'b10) and digit 1 (2'b01).
- R4: At most one bit of `dig_en_n_o` is ever low. After the first tick, exactly one bit is low.
- R5: Segment bit i drives segment a+i (bit 0 = a, bit 6 = g), active low. Hex digits 0..F use these lit-segment sets:
  - 0 = abcdef, 1 = bc, 2 = abdeg, 3 = abcdg
  - 4 = bcfg, 5 = acdfg, 6 = acdefg, 7 = abc
  - 8 = all seven, 9 = abcdfg, A = abcefg, b = cdefg
  - C = adef, d = bcdeg, E = adefg, F = aefg
- R6: On a tick, the segment pattern and the digit enable update on the same clock edge. The pattern is the decode of the nibble belonging to the newly lit digit (`nib0_i` for digit 0, `nib1_i` for digit 1), sampled at that edge.
- R7: Between ticks, changes on `nib0_i` or `nib1_i` have no effect. `seg_n_o` and `dig_en_n_o` hold their values until the next tick.
- R8: A reset applied mid-run blanks both outputs on the next clock. It also restarts the tick phase from an accumulator value of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| nib0_i | input | 4 | Hex value shown on digit 0 |
| nib1_i | input | 4 | Hex value shown on digit 1 |
| seg_n_o | output | 7 | Segment lines, active low, bit 0 = segment a |
| dig_en_n_o | output | 2 | Digit power enables, active low, bit i = digit i |

## Verification
Every result of this block appears one clock after the edge that causes it. A reset shows up at the edge that samples it. A tick's new enable and segment pattern appear together at that same edge, and inputs that change between ticks have no visible effect until the following tick. The bench drives inputs on the falling edge and samples all outputs on the falling edge. It keeps a reference accumulator stepped on the rising edge, so the expected tick edge is known exactly and every check lands half a cycle after the edge that sets the value. The tick-rate check counts enable changes over a window whose length gives an exact, non-rounded number of ticks.

// File: rtl/dual_seg7_mux_pkg.sv
package dual_seg7_mux_pkg;

    localparam int NIB_W = 4;
    localparam int SEG_W = 7;
    localparam int NDIG  = 2;

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [NDIG-1:0]  en_t;

    typedef struct packed {
        seg_t seg_n;
        en_t  en_n;
    } disp_t;

    localparam seg_t SEG_BLANK = '1;
    localparam en_t  EN_OFF    = '1;

    // active-low pattern, bit 0 = segment a
    function automatic seg_t hex_to_seg_n(input nib_t v);
        seg_t lit;
        case (v)
            4'h0: lit = 7'b0111111;
            4'h1: lit = 7'b0000110;
            4'h2: lit = 7'b1011011;
            4'h3: lit = 7'b1001111;
            4'h4: lit = 7'b1100110;
            4'h5: lit = 7'b1101101;
            4'h6: lit = 7'b1111101;
            4'h7: lit = 7'b0000111;
            4'h8: lit = 7'b1111111;
            4'h9: lit = 7'b1101111;
            4'hA: lit = 7'b1110111;
            4'hB: lit = 7'b1111100;
            4'hC: lit = 7'b0111001;
            4'hD: lit = 7'b1011110;
            4'hE: lit = 7'b1111001;
            default: lit = 7'b1110001;
        endcase
        return ~lit;
    endfunction

endpackage

// File: rtl/dual_seg7_mux_phase_acc.sv
module dual_seg7_mux_phase_acc #(
    parameter int ACC_W = 24,
    parameter int INC   = 42
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    localparam logic [ACC_W:0] INC_V = (ACC_W+1)'(INC);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    assign sum    = {1'b0, acc_q} + INC_V;
    assign tick_o = sum[ACC_W];

    always_ff @(posedge clk_i) begin
        if (rst_i) acc_q <= '0;
        else       acc_q <= sum[ACC_W-1:0];
    end

    generate
        if (2 * INC <= (1 << ACC_W)) begin : g_sparse
            // R2
            tick_spacing_chk: assert property (@(posedge clk_i) disable iff (rst_i)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/dual_seg7_mux_digit_sel.sv
module dual_seg7_mux_digit_sel (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    output logic sel_next_o
);
    logic sel_q;

    assign sel_next_o = tick_i ? ~sel_q : sel_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) sel_q <= 1'b0;
        else       sel_q <= sel_next_o;
    end

    // R3
    sel_toggle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_i |=> (sel_q != $past(sel_q)));
endmodule

// File: rtl/dual_seg7_mux_hex_dec.sv
module dual_seg7_mux_hex_dec
    import dual_seg7_mux_pkg::*;
(
    input  nib_t nib_i,
    output seg_t seg_n_o
);
    assign seg_n_o = hex_to_seg_n(nib_i);

    // R5
    always_comb begin
        glyph_lit_chk: assert ($countones(~seg_n_o) >= 2);
    end
endmodule

// File: rtl/dual_seg7_mux_out_reg.sv
module dual_seg7_mux_out_reg
    import dual_seg7_mux_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  tick_i,
    input  logic  sel_next_i,
    input  seg_t  seg_n_i,
    output disp_t disp_o
);
    disp_t disp_q;
    en_t   en_n_next;

    generate
        for (genvar d = 0; d < NDIG; d++) begin : g_en
            assign en_n_next[d] = !(sel_next_i == d[0]);
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            disp_q.seg_n <= SEG_BLANK;
            disp_q.en_n  <= EN_OFF;
        end else if (tick_i) begin
            disp_q.seg_n <= seg_n_i;
            disp_q.en_n  <= en_n_next;
        end
    end

    assign disp_o = disp_q;

    // R1
    reset_blank_chk: assert property (@(posedge clk_i)
        rst_i |=> (disp_q.seg_n == SEG_BLANK && disp_q.en_n == EN_OFF));
    // R4
    one_digit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(~disp_q.en_n));
    // R7
    hold_between_ticks_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick_i |=> ($stable(disp_q.seg_n) && $stable(disp_q.en_n)));
    // R6
    tick_switch_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_i |=> (disp_q.en_n != $past(disp_q.en_n) && disp_q.en_n != EN_OFF));
    // R6
    lit_has_glyph_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (disp_q.en_n != EN_OFF) |-> (disp_q.seg_n != SEG_BLANK));
endmodule

// File: rtl/dual_seg7_mux.sv
module dual_seg7_mux
    import dual_seg7_mux_pkg::*;
#(
    parameter int ACC_W = 24,
    parameter int INC   = 42
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [3:0] nib0_i,
    input  logic [3:0] nib1_i,
    output logic [6:0] seg_n_o,
    output logic [1:0] dig_en_n_o
);
    logic  tick;
    logic  sel_next;
    nib_t  nib_pick;
    seg_t  seg_dec;
    disp_t disp;

    dual_seg7_mux_phase_acc #(.ACC_W(ACC_W), .INC(INC)) u_acc (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .tick_o(tick)
    );

    dual_seg7_mux_digit_sel u_sel (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .tick_i    (tick),
        .sel_next_o(sel_next)
    );

    assign nib_pick = sel_next ? nib1_i : nib0_i;

    dual_seg7_mux_hex_dec u_dec (
        .nib_i  (nib_pick),
        .seg_n_o(seg_dec)
    );

    dual_seg7_mux_out_reg u_out (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .tick_i    (tick),
        .sel_next_i(sel_next),
        .seg_n_i   (seg_dec),
        .disp_o    (disp)
    );

    assign seg_n_o    = disp.seg_n;
    assign dig_en_n_o = disp.en_n;
endmodule

// File: tb/dual_seg7_mux_tb.sv
module dual_seg7_mux_tb;
    localparam int ACC_W = 6;
    localparam int INC   = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] nib0 = 4'h0;
    logic [3:0] nib1 = 4'h0;
    logic [6:0] seg_n;
    logic [1:0] en_n;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    dual_seg7_mux #(.ACC_W(ACC_W), .INC(INC)) u_dut (
        .clk_i(clk), .rst_i(rst), .nib0_i(nib0), .nib1_i(nib1),
        .seg_n_o(seg_n), .dig_en_n_o(en_n)
    );

    // expected lit segments (bit 0 = a), from R5
    function automatic logic [6:0] lit_set(input logic [3:0] v);
        logic [6:0] t [16];
        t[0]=7'h3F; t[1]=7'h06; t[2]=7'h5B; t[3]=7'h4F;
        t[4]=7'h66; t[5]=7'h6D; t[6]=7'h7D; t[7]=7'h07;
        t[8]=7'h7F; t[9]=7'h6F; t[10]=7'h77; t[11]=7'h7C;
        t[12]=7'h39; t[13]=7'h5E; t[14]=7'h79; t[15]=7'h71;
        return t[v];
    endfunction

    // reference model stepped on the rising edge
    int         m_acc = 0;
    bit         m_sel = 0;
    bit         m_tick = 0;
    logic [6:0] e_seg = 7'h7F;
    logic [1:0] e_en  = 2'b11;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_acc = 0; m_sel = 0; m_tick = 0;
            e_seg = 7'h7F; e_en = 2'b11;
        end else begin
            m_tick = (m_acc + INC) >= (1 << ACC_W);
            m_acc  = (m_acc + INC) % (1 << ACC_W);
            if (m_tick) begin
                m_sel = ~m_sel;
                e_en  = m_sel ? 2'b01 : 2'b10;
                e_seg = ~lit_set(m_sel ? nib1 : nib0);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic step_chk(input string req);
        @(negedge clk);
        chk(req, {25'd0, seg_n}, {25'd0, e_seg});
        chk(req, {30'd0, en_n}, {30'd0, e_en});
        checks++;
        if ($countones(~en_n) > 1) begin
            errors++;
            $display("FAIL R4: actual=%b expected=at most one low", en_n);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk("R1", {25'd0, seg_n}, 32'h7F);
        chk("R1", {30'd0, en_n}, 32'h3);
        rst = 1'b0;
        // first tick at edge 13 (13*5=65 >= 64); before it stay blank
        for (int i = 0; i < 12; i++) step_chk("R1");
        chk("R1", {30'd0, en_n}, 32'h3);
        step_chk("R3");
        chk("R3", {30'd0, en_n}, 32'h1);
    endtask

    task automatic t_rate();
        int changes = 0;
        logic [1:0] prev;
        do_reset();
        prev = en_n;
        for (int i = 0; i < 640; i++) begin
            step_chk("R2");
            if (en_n != prev) changes++;
            prev = en_n;
        end
        chk("R2", changes, 32'd50);
    endtask

    task automatic t_all_hex();
        do_reset();
        for (int v = 0; v < 16; v++) begin
            nib0 = 4'(v);
            nib1 = 4'(15 - v);
            for (int i = 0; i < 30; i++) step_chk("R5");
        end
    endtask

    task automatic t_hold();
        logic [6:0] s0;
        logic [1:0] e0;
        do_reset();
        nib0 = 4'h8; nib1 = 4'h1;
        for (int k = 0; k < 6; k++) begin
            do step_chk("R6"); while (!m_tick);
            s0 = seg_n; e0 = en_n;
            nib0 = ~nib0; nib1 = ~nib1;
            @(negedge clk);
            if (!m_tick) begin
                chk("R7", {25'd0, seg_n}, {25'd0, s0});
                chk("R7", {30'd0, en_n}, {30'd0, e0});
            end
        end
    endtask

    task automatic t_midreset();
        do_reset();
        nib0 = 4'h2; nib1 = 4'hE;
        for (int i = 0; i < 40; i++) step_chk("R8");
        chk("R8", {31'd0, en_n != 2'b11}, 32'd1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk("R8", {25'd0, seg_n}, 32'h7F);
        chk("R8", {30'd0, en_n}, 32'h3);
        rst = 1'b0;
        for (int i = 0; i < 12; i++) step_chk("R8");
        chk("R8", {30'd0, en_n}, 32'h3);
        step_chk("R8");
        chk("R8", {30'd0, en_n}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_rate();
        t_all_hex();
        t_hold();
        t_midreset();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule